// File: doc/BRIEF.md
# Cyclic Layer Flow Sequencer

This block is the synchronous controller of a column-parallel processing pipeline with four stages: row storage, convolution, pooling and quantization. One small set of stages is reused for every layer of a network. The sequencer walks a stored layer program. For each layer it fetches a descriptor and steps the processing window down one image row per clock. It raises the stage enables and bypass selects at the cycle each stage handles a row. It also holds the layer's kernel height, weight reference, noise damping setting and converter resolution on dedicated outputs.

For every layer except the final one, pooling output is routed back into storage. After the final layer, pooling output goes through the quantizer instead, and each quantized row produces a write strobe with a sequential address into the feature memory. The stages themselves are modelled as delay lines of fixed latency, set by the parameters `STORE_LAT`, `CONV_LAT`, `POOL_LAT` and `QUANT_LAT`. From these, `PIPE_LAT = STORE_LAT + CONV_LAT + POOL_LAT`.

Top module: `layer_flow_seq`

## Requirements
- R1: After reset, `busy`, `done`, `row_step`, all stage enables and `fm_we` are 0 and `fm_addr` is 0.
- R2: A `start` sampled while idle reads descriptor 0 in the next cycle. The layer's row timesteps follow in consecutive cycles: `row_step` is 1 for exactly `rows` cycles, and `row_idx` counts 0 to rows-1.
- R3: The program memory is read combinationally at `prog_addr`, which equals the layer index during the fetch cycle. The descriptor bits are: [1:0] layer type, [9:2] rows, [13:10] kernel height, [14] pool bypass, [16:15] damping, [17] final-layer flag, [23:18] weight reference and [27:24] converter resolution. These fields appear on `kern_h`, `kern_ref`, `damp_sel` and `adc_bits` during every row timestep of the layer.
- R4: A layer type of 1 bypasses convolution. In that case `sel_conv_byp`=1 and `cv_en` stays 0. Any other type gives `cv_en`=1 exactly STORE_LAT cycles after each `row_step`.
- R5: With pool bypass set, `sel_pool_byp`=1 and `pl_en` stays 0. Otherwise `pl_en`=1 exactly STORE_LAT+CONV_LAT cycles after each `row_step`.
- R6: PIPE_LAT cycles after each `row_step`, a non-final layer pulses `loop_wr` and the final layer pulses `q_en`. `sel_loopback` is 1 exactly for non-final layers.
- R7: The first row of the next layer comes exactly PIPE_LAT+3 cycles after the last row of the previous layer, so no row of the previous layer is still in the pipeline when the next descriptor is fetched.
- R8: A layer with rows=0 issues no row timestep but still spends the PIPE_LAT drain cycles before moving on.
- R9: `fm_we` pulses QUANT_LAT cycles after each `q_en`. `fm_addr` starts at 0 on each accepted start and increments after each write.
- R10: `done` is a single-cycle pulse PIPE_LAT+QUANT_LAT+1 cycles after the final layer's last row. `busy` is 1 from the fetch of descriptor 0 through the `done` cycle, and 0 afterwards.
- R11: The last program slot (PROG_DEPTH-1) is treated as the final layer even when its flag is 0.
- R12: A `start` that arrives while busy has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin running the program (accepted only while idle) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| prog_addr | output | PA_W | Program memory address (layer index) |
| prog_data | input | 28 | Descriptor read combinationally at prog_addr |
| row_step | output | 1 | Row timestep; storage stage takes a new row |
| row_idx | output | 8 | Row index within the layer |
| cv_en | output | 1 | Convolution stage active on a row |
| pl_en | output | 1 | Pooling stage active on a row |
| loop_wr | output | 1 | Pooling output written back to storage |
| q_en | output | 1 | Pooling output handed to the quantizer |
| sel_conv_byp | output | 1 | Convolution bypass route selected |
| sel_pool_byp | output | 1 | Pooling bypass route selected |
| sel_loopback | output | 1 | Pooling output routed back to storage |
| kern_h | output | 4 | Kernel height of the current layer |
| kern_ref | output | 6 | Kernel weight reference of the current layer |
| damp_sel | output | 2 | Noise damping setting for convolution |
| adc_bits | output | 4 | Converter resolution for quantization |
| fm_we | output | 1 | Feature memory write strobe |
| fm_addr | output | ADDR_W | Feature memory write address |

## Verification
The bench computes, for every cycle of a run, the schedule of every output from descriptor arithmetic alone. It runs this model against programs that sweep all four layer types and both pool-bypass settings across two-layer programs, and a range of single-layer row counts. The sweep separates conv-bypass and pool-bypass decoding errors from tap-position errors in the stage enables. It also tells a routing fault between loopback and quantization apart from an error in which layer counts as final. Dedicated programs cover a zero-row layer and a program with no final flag, to check the drain wait and forced termination. The same program is rerun with a stray `start` in mid-run and after a previous run, which exposes any address reset or restart that should not happen.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

  localparam int LTYPE_W = 2;
  localparam int ROWS_W  = 8;
  localparam int KH_W    = 4;
  localparam int DAMP_W  = 2;
  localparam int WREF_W  = 6;
  localparam int RES_W   = 4;
  localparam int DESC_W  = RES_W + WREF_W + 1 + DAMP_W + 1 + KH_W + ROWS_W + LTYPE_W;

  localparam logic [LTYPE_W-1:0] LT_CONV_SKIP = 2'd1;

  // Field order LSB first: ltype, rows, kh, pool bypass, damping, final, wref, res
  typedef struct packed {
    logic [RES_W-1:0]   res;
    logic [WREF_W-1:0]  wref;
    logic               fin;
    logic [DAMP_W-1:0]  damp;
    logic               pool_skip;
    logic [KH_W-1:0]    kh;
    logic [ROWS_W-1:0]  rows;
    logic [LTYPE_W-1:0] ltype;
  } layer_desc_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_RUN,
    ST_DRAIN,
    ST_NEXT,
    ST_QUANT,
    ST_DONE
  } seq_state_t;

  function automatic int safe_clog2(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic logic conv_skipped(input layer_desc_t d);
    return d.ltype == LT_CONV_SKIP;
  endfunction

  function automatic logic no_rows(input layer_desc_t d);
    return d.rows == '0;
  endfunction

  function automatic logic final_row(input logic [ROWS_W-1:0] r, input layer_desc_t d);
    return r == (d.rows - ROWS_W'(1));
  endfunction

  // Total rows-to-pool-output latency of the three chained stages
  function automatic int pipe_depth(input int s, input int c, input int p);
    return s + c + p;
  endfunction

endpackage

// File: rtl/lfs_delay.sv
module lfs_delay #(
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  output logic [DEPTH-1:0] taps
);

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) taps <= '0;
        else        taps <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) taps <= '0;
        else        taps <= {taps[DEPTH-2:0], din};
      end
    end
  endgenerate

endmodule

// File: rtl/lfs_fsm.sv
module lfs_fsm
  import lfs_pkg::*;
#(
  parameter int PROG_DEPTH = 8,
  parameter int DRAIN_CYC  = 4,
  parameter int QUANT_CYC  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  layer_desc_t                   desc_in,
  output seq_state_t                    state,
  output logic [safe_clog2(PROG_DEPTH)-1:0] layer_idx,
  output layer_desc_t                   desc_q,
  output logic [ROWS_W-1:0]             row_q,
  output logic                          layer_last,
  output logic                          start_acc
);

  localparam int PA_W   = safe_clog2(PROG_DEPTH);
  localparam int WMAX   = (DRAIN_CYC > QUANT_CYC) ? DRAIN_CYC : QUANT_CYC;
  localparam int WCNT_W = safe_clog2(WMAX + 1);
  localparam logic [PA_W-1:0]   LAST_SLOT = PA_W'(PROG_DEPTH - 1);
  localparam logic [WCNT_W-1:0] DRAIN_END = WCNT_W'(DRAIN_CYC - 1);
  localparam logic [WCNT_W-1:0] QUANT_END = WCNT_W'(QUANT_CYC - 1);

  logic [WCNT_W-1:0] wait_q;

  assign start_acc  = start && (state == ST_IDLE);
  assign layer_last = desc_q.fin || (layer_idx == LAST_SLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      layer_idx <= '0;
      desc_q    <= '0;
      row_q     <= '0;
      wait_q    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_LOAD;
            layer_idx <= '0;
          end
        end
        ST_LOAD: begin
          desc_q <= desc_in;
          row_q  <= '0;
          wait_q <= '0;
          state  <= no_rows(desc_in) ? ST_DRAIN : ST_RUN;
        end
        ST_RUN: begin
          if (final_row(row_q, desc_q)) begin
            state  <= ST_DRAIN;
            wait_q <= '0;
          end else begin
            row_q <= row_q + ROWS_W'(1);
          end
        end
        ST_DRAIN: begin
          if (wait_q == DRAIN_END) begin
            wait_q <= '0;
            state  <= layer_last ? ST_QUANT : ST_NEXT;
          end else begin
            wait_q <= wait_q + WCNT_W'(1);
          end
        end
        ST_NEXT: begin
          layer_idx <= layer_idx + PA_W'(1);
          state     <= ST_LOAD;
        end
        ST_QUANT: begin
          if (wait_q == QUANT_END) begin
            wait_q <= '0;
            state  <= ST_DONE;
          end else begin
            wait_q <= wait_q + WCNT_W'(1);
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lfs_stage_track.sv
module lfs_stage_track #(
  parameter int STORE_LAT = 1,
  parameter int CONV_LAT  = 2,
  parameter int POOL_LAT  = 1,
  parameter int QUANT_LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic row_step,
  input  logic conv_skip,
  input  logic pool_skip,
  input  logic last_layer,
  output logic cv_en,
  output logic pl_en,
  output logic loop_wr,
  output logic q_en,
  output logic fm_we,
  output logic pipe_any
);

  localparam int PIPE_LAT = STORE_LAT + CONV_LAT + POOL_LAT;
  localparam int CV_TAP   = STORE_LAT - 1;
  localparam int PL_TAP   = STORE_LAT + CONV_LAT - 1;

  logic [PIPE_LAT-1:0]  row_tok;
  logic [QUANT_LAT-1:0] q_tok;
  logic                 pool_out;

  lfs_delay #(.DEPTH(PIPE_LAT)) u_row_line (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (row_step),
    .taps (row_tok)
  );

  assign pool_out = row_tok[PIPE_LAT-1];
  assign cv_en    = row_tok[CV_TAP] && !conv_skip;
  assign pl_en    = row_tok[PL_TAP] && !pool_skip;
  assign loop_wr  = pool_out && !last_layer;
  assign q_en     = pool_out && last_layer;
  assign pipe_any = |row_tok;

  lfs_delay #(.DEPTH(QUANT_LAT)) u_quant_line (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (q_en),
    .taps (q_tok)
  );

  assign fm_we = q_tok[QUANT_LAT-1];

endmodule

// File: rtl/lfs_feat_addr.sv
module lfs_feat_addr #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr,
  output logic [ADDR_W-1:0] addr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr <= '0;
    else if (clear) addr <= '0;
    else if (wr)    addr <= addr + ADDR_W'(1);
  end

endmodule

// File: rtl/layer_flow_seq.sv
module layer_flow_seq
  import lfs_pkg::*;
#(
  parameter int PROG_DEPTH = 8,
  parameter int STORE_LAT  = 1,
  parameter int CONV_LAT   = 2,
  parameter int POOL_LAT   = 1,
  parameter int QUANT_LAT  = 3,
  parameter int ADDR_W     = 10
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  start,
  output logic                                  busy,
  output logic                                  done,
  output logic [safe_clog2(PROG_DEPTH)-1:0]     prog_addr,
  input  logic [DESC_W-1:0]                     prog_data,
  output logic                                  row_step,
  output logic [ROWS_W-1:0]                     row_idx,
  output logic                                  cv_en,
  output logic                                  pl_en,
  output logic                                  loop_wr,
  output logic                                  q_en,
  output logic                                  sel_conv_byp,
  output logic                                  sel_pool_byp,
  output logic                                  sel_loopback,
  output logic [KH_W-1:0]                       kern_h,
  output logic [WREF_W-1:0]                     kern_ref,
  output logic [DAMP_W-1:0]                     damp_sel,
  output logic [RES_W-1:0]                      adc_bits,
  output logic                                  fm_we,
  output logic [ADDR_W-1:0]                     fm_addr
);

  localparam int PIPE_LAT = pipe_depth(STORE_LAT, CONV_LAT, POOL_LAT);

  seq_state_t  state;
  layer_desc_t desc_q;
  layer_desc_t desc_in;
  logic        layer_last;
  logic        start_acc;
  // Named internal events observed by the bound checker
  logic        load_evt;
  logic        pipe_any;

  assign desc_in = layer_desc_t'(prog_data);

  lfs_fsm #(
    .PROG_DEPTH(PROG_DEPTH),
    .DRAIN_CYC (PIPE_LAT),
    .QUANT_CYC (QUANT_LAT)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .desc_in   (desc_in),
    .state     (state),
    .layer_idx (prog_addr),
    .desc_q    (desc_q),
    .row_q     (row_idx),
    .layer_last(layer_last),
    .start_acc (start_acc)
  );

  assign load_evt = (state == ST_LOAD);
  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_DONE);
  assign row_step = (state == ST_RUN);

  assign sel_conv_byp = busy && conv_skipped(desc_q);
  assign sel_pool_byp = busy && desc_q.pool_skip;
  assign sel_loopback = busy && !layer_last;
  assign kern_h       = desc_q.kh;
  assign kern_ref     = desc_q.wref;
  assign damp_sel     = desc_q.damp;
  assign adc_bits     = desc_q.res;

  lfs_stage_track #(
    .STORE_LAT(STORE_LAT),
    .CONV_LAT (CONV_LAT),
    .POOL_LAT (POOL_LAT),
    .QUANT_LAT(QUANT_LAT)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_step  (row_step),
    .conv_skip (conv_skipped(desc_q)),
    .pool_skip (desc_q.pool_skip),
    .last_layer(layer_last),
    .cv_en     (cv_en),
    .pl_en     (pl_en),
    .loop_wr   (loop_wr),
    .q_en      (q_en),
    .fm_we     (fm_we),
    .pipe_any  (pipe_any)
  );

  lfs_feat_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(start_acc),
    .wr   (fm_we),
    .addr (fm_addr)
  );

endmodule

// File: rtl/lfs_chk.sv
module lfs_chk #(
  parameter int ROW_W  = 8,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              row_step,
  input logic [ROW_W-1:0]  row_idx,
  input logic              loop_wr,
  input logic              q_en,
  input logic              fm_we,
  input logic [ADDR_W-1:0] fm_addr,
  input logic              load_evt,
  input logic              pipe_any
);

  // R2
  row_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_step && $past(row_step) |-> row_idx == ROW_W'($past(row_idx) + 1'b1));

  // R6
  route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(loop_wr && q_en));

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> !pipe_any);

  // R9
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fm_we |=> fm_addr == ADDR_W'($past(fm_addr) + 1'b1));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !row_step);

endmodule

bind layer_flow_seq lfs_chk #(.ROW_W(lfs_pkg::ROWS_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .done    (done),
  .row_step(row_step),
  .row_idx (row_idx),
  .loop_wr (loop_wr),
  .q_en    (q_en),
  .fm_we   (fm_we),
  .fm_addr (fm_addr),
  .load_evt(load_evt),
  .pipe_any(pipe_any)
);

// File: tb/tb_layer_flow_seq.sv
module tb_layer_flow_seq;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int SL = 1, CL = 2, PL = 1, QL = 3;
  localparam int L  = SL + CL + PL;
  localparam int AW = 6;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic busy, done, row_step, cv_en, pl_en, loop_wr, q_en;
  logic sel_conv_byp, sel_pool_byp, sel_loopback, fm_we;
  logic [1:0] prog_addr;
  logic [27:0] prog_data;
  logic [7:0] row_idx;
  logic [3:0] kern_h, adc_bits;
  logic [5:0] kern_ref;
  logic [1:0] damp_sel;
  logic [AW-1:0] fm_addr;

  logic [27:0] pmem [DEPTH];
  assign prog_data = pmem[prog_addr];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  layer_flow_seq #(
    .PROG_DEPTH(DEPTH), .STORE_LAT(SL), .CONV_LAT(CL), .POOL_LAT(PL),
    .QUANT_LAT(QL), .ADDR_W(AW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .prog_addr(prog_addr), .prog_data(prog_data), .row_step(row_step),
    .row_idx(row_idx), .cv_en(cv_en), .pl_en(pl_en), .loop_wr(loop_wr),
    .q_en(q_en), .sel_conv_byp(sel_conv_byp), .sel_pool_byp(sel_pool_byp),
    .sel_loopback(sel_loopback), .kern_h(kern_h), .kern_ref(kern_ref),
    .damp_sel(damp_sel), .adc_bits(adc_bits), .fm_we(fm_we), .fm_addr(fm_addr)
  );

  function automatic logic [27:0] mk(input int lt, input int rows, input int kh,
                                     input int pb, input int dm, input int fin,
                                     input int wr, input int rs);
    return {rs[3:0], wr[5:0], fin[0], dm[1:0], pb[0], kh[3:0], rows[7:0], lt[1:0]};
  endfunction

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  int s_at [DEPTH];
  int nl;

  function automatic bit in_rows(input int i, input int c);
    int r = int'(pmem[i][9:2]);
    return (c >= s_at[i]) && (c < s_at[i] + r);
  endfunction

  // Run the stored program; poke>0 drives a stray start in that cycle (R12)
  task automatic run_prog(input int poke);
    int dcyc, lastr;
    nl = DEPTH;
    for (int i = 0; i < DEPTH; i++) begin
      if (pmem[i][17]) begin nl = i + 1; break; end
    end
    s_at[0] = 1;
    for (int i = 1; i < nl; i++)
      s_at[i] = s_at[i-1] + int'(pmem[i-1][9:2]) + L + 2;
    lastr = int'(pmem[nl-1][9:2]);
    dcyc = s_at[nl-1] + lastr + L + QL;
    @(negedge clk) start = 1;
    for (int c = 0; c <= dcyc + 2; c++) begin
      int e_row = 0, e_idx = 0, e_cv = 0, e_pl = 0, e_lp = 0, e_q = 0, e_we = 0, e_fa = 0;
      @(negedge clk);
      for (int i = 0; i < nl; i++) begin
        if (in_rows(i, c)) begin
          e_row = 1;
          e_idx = c - s_at[i];
          chk("R3", "kern_h", kern_h, int'(pmem[i][13:10]));
          chk("R3", "kern_ref", kern_ref, int'(pmem[i][23:18]));
          chk("R3", "damp_sel", damp_sel, int'(pmem[i][16:15]));
          chk("R3", "adc_bits", adc_bits, int'(pmem[i][27:24]));
          chk("R4", "sel_conv_byp", sel_conv_byp, int'(pmem[i][1:0] == 2'd1));
          chk("R5", "sel_pool_byp", sel_pool_byp, int'(pmem[i][14]));
          chk("R6", "sel_loopback", sel_loopback, int'(i != nl - 1));
        end
        if (c == s_at[i] - 1) chk("R3", "prog_addr", prog_addr, i);
        if (in_rows(i, c - SL) && pmem[i][1:0] != 2'd1) e_cv = 1;
        if (in_rows(i, c - SL - CL) && !pmem[i][14]) e_pl = 1;
        if (in_rows(i, c - L) && i != nl - 1) e_lp = 1;
      end
      if (in_rows(nl - 1, c - L)) e_q = 1;
      if (in_rows(nl - 1, c - L - QL)) e_we = 1;
      for (int k = 0; k < lastr; k++)
        if (s_at[nl-1] + k + L + QL < c) e_fa++;
      chk("R2", "row_step", row_step, e_row);
      if (e_row) chk("R2", "row_idx", row_idx, e_idx);
      chk("R4", "cv_en", cv_en, e_cv);
      chk("R5", "pl_en", pl_en, e_pl);
      chk("R6 R7", "loop_wr", loop_wr, e_lp);
      chk("R6 R11", "q_en", q_en, e_q);
      chk("R9", "fm_we", fm_we, e_we);
      chk("R9 R12", "fm_addr", fm_addr, e_fa);
      chk("R10", "done", done, int'(c == dcyc));
      chk("R10", "busy", busy, int'(c <= dcyc));
      start = (c == poke);
    end
    start = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) pmem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "row_step", row_step, 0);
    chk("R1", "fm_we", fm_we, 0);
    chk("R1", "fm_addr", fm_addr, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1", "cv_en", cv_en, 0);

    // Mixed three-layer program: R2..R7, R9, R10
    pmem[0] = mk(0, 3, 3, 0, 2, 0, 5, 7);
    pmem[1] = mk(1, 2, 1, 1, 1, 0, 9, 4);
    pmem[2] = mk(2, 4, 5, 0, 3, 1, 33, 10);
    run_prog(0);

    // R8 zero-row middle layer
    pmem[0] = mk(0, 2, 2, 1, 0, 0, 1, 2);
    pmem[1] = mk(3, 0, 7, 0, 1, 0, 2, 3);
    pmem[2] = mk(0, 2, 4, 0, 2, 1, 3, 8);
    run_prog(0);

    // R11 no final flag anywhere; R12 stray start mid-run
    pmem[0] = mk(0, 1, 1, 0, 0, 0, 4, 1);
    pmem[1] = mk(1, 3, 2, 0, 1, 0, 8, 2);
    pmem[2] = mk(2, 2, 3, 1, 2, 0, 16, 3);
    pmem[3] = mk(3, 3, 9, 0, 3, 0, 62, 15);
    run_prog(9);
    run_prog(25);

    // Sweep: layer type x pool bypass over two-layer programs
    for (int lt = 0; lt < 4; lt++) begin
      for (int pb = 0; pb < 2; pb++) begin
        pmem[0] = mk(lt, 2, lt + 1, pb, lt, 0, lt * 3, pb + 4);
        pmem[1] = mk(3 - lt, 2, 6, 1 - pb, 1, 1, 40 + lt, 6);
        run_prog(0);
      end
    end

    // Sweep: single-layer row counts
    for (int r = 1; r <= 6; r++) begin
      pmem[0] = mk(r % 4, r, r, r % 2, r % 4, 1, r, r);
      run_prog(0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule